// File: doc/BRIEF.md
# Two-Stage Hill-Climbing Power Tracker

This block is the digital sequencer of a power tracker for a reconfigurable switched-capacitor energy harvester. It stays in an idle state, with all tracking logic still, until a trigger arrives from the host node. It then runs two hill climbs, one after the other. The first climb sweeps a 4-bit conversion-ratio code. The second sweeps a 4-bit switching-frequency code. Each climb moves one setting per tracking-step pulse.

A power arbiter outside the block compares successive output peaks and raises a flag once the latest step has made the peak worse. A climb always finds the peak one step too late. On the next step pulse after the flag, the sequencer therefore counts that stage's code down once, back to the last setting that improved the peak, and then hands over to the next stage. After the frequency climb ends, the block pulses a done flag and returns to idle. Both codes stay on the outputs until the next trigger.

The trigger and step inputs may come from another timing domain. Each passes through a synchronizer and a rising-edge detector before it is used. The ratio code is decoded into switch controls outside this block. The frequency code programs an oscillator outside this block.

Top module: `mppt_2d_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle (`ratio_en` = 0, `freq_en` = 0), both codes go to 0, and `done` goes to 0.
- R2: The stage enables are driven from a 2-bit state: idle = 00, ratio stage = 01, frequency stage = 10. `ratio_en` is high only in the ratio stage, `freq_en` only in the frequency stage, and the two are never high together.
- R3: In idle, a rising edge on `trig_in` starts the ratio stage and reloads both codes to 0. In idle, step pulses do not change either code.
- R4: A rising edge on `trig_in` or `step_in` takes effect at the third rising clock edge, counting the first edge that samples the new level. In an active stage, a step taken while `peak_passed` is low raises that stage's code by one. `peak_passed` is sampled at the same edge that applies the step.
- R5: In an active stage, a step taken while `peak_passed` is high and the code is above 0 lowers the code by exactly one and ends the stage. After the ratio stage, the frequency stage begins.
- R6: Ratio code 0 is the highest ratio (8×), and higher codes give lower ratios. A step with `peak_passed` low at ratio code 15 keeps the code at 15 and starts the frequency stage.
- R7: Frequency code 0 is the highest frequency. The code never goes above 12. A step with `peak_passed` low at code 12 keeps the code at 12 and ends the frequency stage.
- R8: A step with `peak_passed` high while the stage's code is 0 keeps the code at 0 and ends the stage.
- R9: When the frequency stage ends, `done` is high for exactly one cycle, in the same cycle the block returns to idle. Both codes then hold their values.
- R10: A trigger edge that arrives during the ratio or frequency stage is ignored. State and codes do not change.
- R11: A `step_in` level that stays high for many cycles counts as a single step.
- R12: A synchronous reset in the middle of a run returns the block to the state described in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Tracking request from the host; its rising edge starts a run |
| step_in | input | 1 | Tracking-step pulse from the regulation loop; its rising edge is one step |
| peak_passed | input | 1 | Arbiter flag, high when the last step lowered the output peak |
| ratio_code | output | 4 | Conversion-ratio setting; 0 is the highest ratio |
| freq_code | output | 4 | Switching-frequency setting, 0 to 12; 0 is the highest frequency |
| ratio_en | output | 1 | High while the ratio stage is active |
| freq_en | output | 1 | High while the frequency stage is active |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
Every state and code of the block is held in registers that drive the ports directly. A wrong state transition therefore shows up on `ratio_en`, `freq_en` or `done` at the same edge that applies the bad step. A wrong count shows up on the code outputs at that same edge.

Other faults appear later. A missing back-off, or a back-off of more than one step, leaves the final code off by one after the run. A failed edge detection makes one held step count more than once. A wrong end-of-range test lets the frequency code rise past 12. The bench compares every port with its own model on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_RATIO = 2'b01,
    ST_FREQ  = 2'b10
  } seq_state_t;
endpackage

// File: rtl/mppt_edge_sync.sv
// Synchronizer followed by a rising-edge detector.
module mppt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN-2:0], din};
  end

  // The newest synchronized sample is high and the one before it was low.
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/mppt_hill_counter.sv
// Up/down setting counter with a fixed start code of 0 and a parameterized last code.
module mppt_hill_counter #(
  parameter int WIDTH = 4,
  parameter int LAST  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             up,
  input  logic             dn,
  output logic [WIDTH-1:0] code,
  output logic             at_start,
  output logic             at_end
);
  localparam logic [WIDTH-1:0] LAST_C = LAST[WIDTH-1:0];

  always_ff @(posedge clk) begin
    if (rst || load)            code <= '0;
    else if (up && code != LAST_C) code <= code + 1'b1;
    else if (dn && code != '0)  code <= code - 1'b1;
  end

  assign at_start = (code == '0);
  assign at_end   = (code == LAST_C);

  // R7
  in_range_chk: assert property (@(posedge clk) disable iff (rst) code <= LAST_C);

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (code == $past(code)) || (code == $past(code) + 1'b1) ||
              (code == $past(code) - 1'b1));
endmodule

// File: rtl/mppt_2d_seq.sv
module mppt_2d_seq #(
  parameter int RATIO_W     = 4,
  parameter int RATIO_LAST  = 15,
  parameter int FREQ_W      = 4,
  parameter int FREQ_LAST   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_in,
  input  logic               step_in,
  input  logic               peak_passed,
  output logic [RATIO_W-1:0] ratio_code,
  output logic [FREQ_W-1:0]  freq_code,
  output logic               ratio_en,
  output logic               freq_en,
  output logic               done
);
  import mppt_pkg::*;

  seq_state_t state, state_nx;
  logic trig_p, step_p;
  logic r_start, r_end, f_start, f_end;
  logic act_r, act_f, leave_r, leave_f;
  logic r_up, r_dn, f_up, f_dn, reload;

  mppt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .din(trig_in), .rise(trig_p));

  mppt_edge_sync #(.STAGES(SYNC_STAGES)) u_step (
    .clk(clk), .rst(rst), .din(step_in), .rise(step_p));

  // Step decision for each stage.
  always_comb begin
    reload  = (state == ST_IDLE) && trig_p;
    act_r   = (state == ST_RATIO) && step_p;
    act_f   = (state == ST_FREQ) && step_p;
    r_up    = act_r && !peak_passed && !r_end;
    r_dn    = act_r && peak_passed && !r_start;
    f_up    = act_f && !peak_passed && !f_end;
    f_dn    = act_f && peak_passed && !f_start;
    leave_r = act_r && (peak_passed || r_end);
    leave_f = act_f && (peak_passed || f_end);
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (trig_p)  state_nx = ST_RATIO;
      ST_RATIO: if (leave_r) state_nx = ST_FREQ;
      ST_FREQ:  if (leave_f) state_nx = ST_IDLE;
      default:               state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= leave_f;
    end
  end

  mppt_hill_counter #(.WIDTH(RATIO_W), .LAST(RATIO_LAST)) u_ratio (
    .clk(clk), .rst(rst), .load(reload), .up(r_up), .dn(r_dn),
    .code(ratio_code), .at_start(r_start), .at_end(r_end));

  mppt_hill_counter #(.WIDTH(FREQ_W), .LAST(FREQ_LAST)) u_freq (
    .clk(clk), .rst(rst), .load(reload), .up(f_up), .dn(f_dn),
    .code(freq_code), .at_start(f_start), .at_end(f_end));

  assign ratio_en = (state == ST_RATIO);
  assign freq_en  = (state == ST_FREQ);

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (rst)
    state != 2'b11);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE) && $past(state == ST_FREQ));

  // R10
  ratio_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FREQ) |=> $stable(ratio_code));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !trig_p) |=> $stable(ratio_code) && $stable(freq_code));
endmodule

// File: tb/tb_mppt_2d_seq.sv
module tb_mppt_2d_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0, step_in = 1'b0, peak_passed = 1'b0;
  logic [3:0] ratio_code, freq_code;
  logic ratio_en, freq_en, done;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model state (0 idle, 1 ratio, 2 frequency).
  int m_state = 0, m_r = 0, m_f = 0;
  bit m_done = 0;
  bit hs1, hs2, hs3, ht1, ht2, ht3;

  mppt_2d_seq dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .step_in(step_in),
    .peak_passed(peak_passed), .ratio_code(ratio_code), .freq_code(freq_code),
    .ratio_en(ratio_en), .freq_en(freq_en), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model, with the input latency given in R4.
  always @(posedge clk) begin
    bit sp, tp, nd;
    cycles++;
    if (rst) begin
      m_state = 0; m_r = 0; m_f = 0; m_done = 0;
      {hs1, hs2, hs3, ht1, ht2, ht3} = '0;
    end else begin
      sp = hs2 && !hs3;
      tp = ht2 && !ht3;
      hs3 = hs2; hs2 = hs1; hs1 = step_in;
      ht3 = ht2; ht2 = ht1; ht1 = trig_in;
      nd = 0;
      if (m_state == 0) begin
        if (tp) begin m_state = 1; m_r = 0; m_f = 0; end
      end else if (m_state == 1) begin
        if (sp) begin
          if (peak_passed) begin if (m_r > 0) m_r--; m_state = 2; end
          else if (m_r == 15) m_state = 2;
          else m_r++;
        end
      end else begin
        if (sp) begin
          if (peak_passed) begin if (m_f > 0) m_f--; m_state = 0; nd = 1; end
          else if (m_f == 12) begin m_state = 0; nd = 1; end
          else m_f++;
        end
      end
      m_done = nd;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    cmp("R4", "ratio_code", ratio_code, m_r);
    cmp("R7", "freq_code", freq_code, m_f);
    cmp("R2", "ratio_en", ratio_en, m_state == 1);
    cmp("R2", "freq_en", freq_en, m_state == 2);
    cmp("R9", "done", done, m_done);
  end

  task automatic pulse_step(bit flag, int hold);
    @(negedge clk); peak_passed = flag; step_in = 1'b1;
    repeat (hold) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_in = 1'b1;
    repeat (2) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    cmp("R1", "ratio_code", ratio_code, 0);
    cmp("R1", "freq_code", freq_code, 0);
    cmp("R1", "enables", {ratio_en, freq_en}, 0);
    rst = 1'b0;
    // R3: steps in idle are ignored
    pulse_step(0, 1); pulse_step(0, 2);
    cmp("R3", "idle ratio", ratio_code, 0);
    pulse_trig();
    cmp("R3", "ratio_en after trigger", ratio_en, 1);
    // R4: three upward steps
    pulse_step(0, 1); pulse_step(0, 1); pulse_step(0, 1);
    cmp("R4", "ratio after 3 steps", ratio_code, 3);
    // R11: long-held step counts once
    pulse_step(0, 20);
    cmp("R11", "ratio after long step", ratio_code, 4);
    // R10: trigger during tuning
    pulse_trig();
    cmp("R10", "ratio after trigger", ratio_code, 4);
    cmp("R10", "ratio_en", ratio_en, 1);
    // R5: back-off and move to frequency
    pulse_step(1, 1);
    cmp("R5", "ratio after back-off", ratio_code, 3);
    cmp("R5", "freq_en", freq_en, 1);
    repeat (5) pulse_step(0, 1);
    cmp("R4", "freq after 5 steps", freq_code, 5);
    pulse_step(1, 1);
    cmp("R9", "freq held", freq_code, 4);
    cmp("R9", "ratio held", ratio_code, 3);
    cmp("R9", "idle", {ratio_en, freq_en}, 0);
    // R3 reload, then R8: flag at start code
    pulse_trig();
    cmp("R3", "ratio reload", ratio_code, 0);
    cmp("R3", "freq reload", freq_code, 0);
    pulse_step(1, 1);
    cmp("R8", "ratio kept at 0", ratio_code, 0);
    cmp("R8", "freq stage", freq_en, 1);
    // R7: frequency saturates at 12
    repeat (13) pulse_step(0, 1);
    cmp("R7", "freq at end", freq_code, 12);
    cmp("R7", "idle after end", freq_en, 0);
    // R6: ratio saturates at 15
    pulse_trig();
    repeat (16) pulse_step(0, 1);
    cmp("R6", "ratio at end", ratio_code, 15);
    cmp("R6", "freq stage", freq_en, 1);
    pulse_step(0, 1); pulse_step(0, 1);
    // R12: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    cmp("R12", "ratio", ratio_code, 0);
    cmp("R12", "freq", freq_code, 0);
    cmp("R12", "enables", {ratio_en, freq_en}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule